// File: doc/BRIEF.md
# Nearest Hamming Distance Identifier

This block decides which enrolled device most likely produced a freshly captured power-up fingerprint. Such a fingerprint is noisy: a few cells flip between power-ups, so an exact lookup fails. Instead the block keeps a small table of reference words, each with a valid bit. On a query it compares the captured word with every valid reference and reports the closest one.

A query is accepted when the block is idle. The captured word and the current threshold are latched, and the table is then scanned one entry per clock. Each comparison counts the differing bits. When the last slot has been compared, a one-cycle result strobe presents the winning slot index and its distance. The strobe also carries a reject flag, set when the best distance is larger than the threshold, and a no-match flag, set when the table held no valid entry. Software-side enrolment writes reference words and valid bits through a plain indexed write port, and the threshold through its own write strobe.

Top module: `hamming_nearest_id`

## Requirements
- R1: The distance between the query word and a reference word is the number of bit positions in which they differ. For a 64-bit word it ranges from 0 to 64.
- R2: The reported index is that of the valid entry with the smallest distance. When several entries share that smallest distance, the lowest index is reported.
- R3: A slot whose valid bit is 0 is never reported. Writing a slot with `wr_keep`=0 removes it from later searches.
- R4: If no slot is valid when a search ends, `res_nomatch` is 1 and `res_idx`, `res_dist` and `res_reject` are all 0.
- R5: A query is accepted on a clock edge where `q_start`=1 and `busy`=0. `busy` is 1 from the next cycle onward. Exactly DEPTH edges after the accepting edge, `res_valid` is 1 for a single cycle and `busy` returns to 0.
- R6: A `q_start` pulse while `busy`=1 is ignored. The running search keeps its query word, its timing and its result.
- R7: `res_reject` is 1 when a match exists and its distance is strictly greater than the threshold that was held at the accepting edge. The threshold resets to 8. A threshold write during a search affects only later queries.
- R8: A table write on the same edge at which that slot is compared does not affect that comparison, because the old contents are used. A write to a slot before its comparison edge is seen by the search.
- R9: After reset, `busy`, `res_valid`, `res_reject` and `res_nomatch` are 0, and every slot is invalid.
- R10: `res_idx`, `res_dist`, `res_reject` and `res_nomatch` hold their values until the next result strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Slot written |
| wr_keep | input | 1 | Valid bit stored with the slot |
| wr_data | input | WIDTH | Reference word stored |
| thr_we | input | 1 | Threshold write strobe |
| thr_in | input | DIST_W | New threshold |
| q_start | input | 1 | Query request |
| q_word | input | WIDTH | Captured word to identify |
| busy | output | 1 | Search in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_idx | output | IDX_W | Winning slot |
| res_dist | output | DIST_W | Winning distance |
| res_reject | output | 1 | Best distance above threshold |
| res_nomatch | output | 1 | No valid slot was present |

## Verification
The search and the table write port can act in the same cycle. This is provoked by writing a slot on exactly the edge at which the scan compares it, and by writing a later slot a few edges before the scan reaches it. The result is judged on the tie rule: the slot written on its own comparison edge would have won the tie had its new contents been used, so the reported index shows which contents the search saw. In the same search, a threshold write and an extra query request land while the scan is running, and the reference model checks that neither changes the result.

// File: rtl/hamming_nearest_id.sv
module hamming_nearest_id #(
  parameter int WIDTH     = 64,
  parameter int DEPTH     = 16,
  parameter int THR_RESET = 8,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int DIST_W   = $clog2(WIDTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_keep,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              thr_we,
  input  logic [DIST_W-1:0] thr_in,
  input  logic              q_start,
  input  logic [WIDTH-1:0]  q_word,
  output logic              busy,
  output logic              res_valid,
  output logic [IDX_W-1:0]  res_idx,
  output logic [DIST_W-1:0] res_dist,
  output logic              res_reject,
  output logic              res_nomatch
);

  logic [WIDTH-1:0]  known [DEPTH];
  logic [DEPTH-1:0]  live;
  logic [DIST_W-1:0] thr, thr_q;
  logic [WIDTH-1:0]  latent;
  logic [IDX_W-1:0]  ptr, best_idx, nxt_idx;
  logic [DIST_W-1:0] best, cur_dist, nxt_best;
  logic              found, nxt_found, take, last;

  function automatic logic [DIST_W-1:0] ones(input logic [WIDTH-1:0] v);
    logic [DIST_W-1:0] n;
    n = '0;
    for (int i = 0; i < WIDTH; i++) n = n + DIST_W'(v[i]);
    return n;
  endfunction

  assign cur_dist  = ones(latent ^ known[ptr]);
  assign take      = live[ptr] && (!found || cur_dist < best);
  assign nxt_found = found | live[ptr];
  assign nxt_best  = take ? cur_dist : best;
  assign nxt_idx   = take ? ptr : best_idx;
  assign last      = (ptr == IDX_W'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (wr_en) known[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      thr  <= DIST_W'(THR_RESET);
    end else begin
      if (wr_en)  live[wr_idx] <= wr_keep;
      if (thr_we) thr <= thr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      res_valid   <= 1'b0;
      res_idx     <= '0;
      res_dist    <= '0;
      res_reject  <= 1'b0;
      res_nomatch <= 1'b0;
      ptr         <= '0;
      found       <= 1'b0;
      best        <= '0;
      best_idx    <= '0;
      latent      <= '0;
      thr_q       <= '0;
    end else begin
      res_valid <= 1'b0;
      if (!busy && q_start) begin
        busy     <= 1'b1;
        ptr      <= '0;
        found    <= 1'b0;
        best     <= '0;
        best_idx <= '0;
        latent   <= q_word;
        thr_q    <= thr;
      end else if (busy) begin
        found    <= nxt_found;
        best     <= nxt_best;
        best_idx <= nxt_idx;
        ptr      <= ptr + 1'b1;
        if (last) begin
          busy        <= 1'b0;
          res_valid   <= 1'b1;
          res_idx     <= nxt_found ? nxt_idx : '0;
          res_dist    <= nxt_found ? nxt_best : '0;
          res_nomatch <= !nxt_found;
          res_reject  <= nxt_found && (nxt_best > thr_q);
        end
      end
    end
  end

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy && $past(busy));
  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && q_start |=> $stable(latent));
  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_reject |-> !res_nomatch);
  p_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_nomatch |-> (res_dist == '0) && (res_idx == '0));
  p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_dist <= DIST_W'(WIDTH));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_idx) && $stable(res_dist));

endmodule

// File: tb/hamming_nearest_id_bench.sv
module hamming_nearest_id_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 64;
  localparam int D  = 16;
  localparam int IW = 4;
  localparam int TW = 7;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_keep = 0, thr_we = 0, q_start = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [W-1:0]  wr_data = '0, q_word = '0;
  logic [TW-1:0] thr_in = '0;
  logic busy, res_valid, res_reject, res_nomatch;
  logic [IW-1:0] res_idx;
  logic [TW-1:0] res_dist;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hamming_nearest_id u_hamming_nearest_id (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_keep(wr_keep),
    .wr_data(wr_data), .thr_we(thr_we), .thr_in(thr_in), .q_start(q_start),
    .q_word(q_word), .busy(busy), .res_valid(res_valid), .res_idx(res_idx),
    .res_dist(res_dist), .res_reject(res_reject), .res_nomatch(res_nomatch));

  logic [W-1:0] m_known [D];
  bit m_live [D];
  bit [W-1:0] m_lat;
  int m_thr, m_thrq, m_ptr, m_best, m_bidx, m_ridx, m_rdist;
  bit m_busy, m_found, m_rv, m_rej, m_nom;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) m_live[i] = 0;
      m_thr = 8; m_busy = 0; m_rv = 0; m_rej = 0; m_nom = 0; m_ridx = 0; m_rdist = 0;
    end else begin
      m_rv = 0;
      if (!m_busy && q_start) begin
        m_busy = 1; m_ptr = 0; m_found = 0; m_best = 0; m_bidx = 0;
        m_lat = q_word; m_thrq = m_thr;
      end else if (m_busy) begin
        int d;
        d = $countones(m_lat ^ m_known[m_ptr]);
        if (m_live[m_ptr] && (!m_found || d < m_best)) begin
          m_found = 1; m_best = d; m_bidx = m_ptr;
        end
        if (m_ptr == D - 1) begin
          m_busy = 0; m_rv = 1; m_nom = !m_found;
          m_ridx = m_found ? m_bidx : 0;
          m_rdist = m_found ? m_best : 0;
          m_rej = m_found && (m_best > m_thrq);
        end
        m_ptr++;
      end
      if (wr_en) begin m_known[wr_idx] = wr_data; m_live[wr_idx] = wr_keep; end
      if (thr_we) m_thr = thr_in;
    end
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check("R5 busy", busy, m_busy);
      check("R5 res_valid", res_valid, m_rv);
      check("R2 res_idx", res_idx, m_ridx);
      check("R1 res_dist", res_dist, m_rdist);
      check("R7 res_reject", res_reject, m_rej);
      check("R4 res_nomatch", res_nomatch, m_nom);
    end
    if (cyc > 200000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [W-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic put(int idx, logic [W-1:0] data, bit keep);
    wr_en = 1; wr_idx = IW'(idx); wr_data = data; wr_keep = keep;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_thr(int t);
    thr_we = 1; thr_in = TW'(t);
    @(negedge clk);
    thr_we = 0;
  endtask

  task automatic query(logic [W-1:0] w, output int lat);
    q_start = 1; q_word = w;
    @(negedge clk);
    q_start = 0;
    lat = 1;
    while (!res_valid) begin @(negedge clk); lat++; end
  endtask

  logic [W-1:0] tab [12];
  logic [W-1:0] lw;
  int lat;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 busy after reset", busy, 0);
    check("R9 res_valid after reset", res_valid, 0);
    check("R9 res_nomatch after reset", res_nomatch, 0);

    query(rnd64(), lat);
    check("R4 empty nomatch", res_nomatch, 1);
    check("R4 empty dist", res_dist, 0);
    check("R4 empty reject", res_reject, 0);
    check("R9 all slots invalid", res_idx, 0);
    check("R5 latency", lat, D + 1);
    @(negedge clk);
    check("R5 single pulse", res_valid, 0);

    for (int i = 0; i < 12; i++) tab[i] = rnd64();
    tab[7] = tab[2];
    for (int i = 0; i < 12; i++) put(i, tab[i], 1);

    lw = tab[5] ^ 64'h8000_0000_0010_0001;
    query(lw, lat);
    check("R1 distance three", res_dist, 3);
    check("R2 nearest slot", res_idx, 5);
    check("R7 under default threshold", res_reject, 0);

    query(tab[2], lat);
    check("R2 tie lowest index", res_idx, 2);
    check("R1 exact distance", res_dist, 0);

    put(2, tab[2], 0);
    query(tab[2], lat);
    check("R3 invalid skipped", res_idx, 7);
    repeat (5) @(negedge clk);
    check("R10 result held", res_idx, 7);

    set_thr(2);
    query(lw, lat);
    check("R7 above threshold", res_reject, 1);
    set_thr(3);
    q_start = 1; q_word = lw;
    @(negedge clk);
    q_start = 0;
    thr_in = 0; thr_we = 1;
    @(negedge clk);
    thr_we = 0;
    while (!res_valid) @(negedge clk);
    check("R7 equal threshold captured", res_reject, 0);
    query(lw, lat);
    check("R7 new threshold used", res_reject, 1);
    set_thr(8);

    lw = rnd64();
    q_start = 1; q_word = lw;
    @(negedge clk);
    q_start = 0;
    for (int k = 1; k <= D + 1 && !res_valid; k++) begin
      if (k == 3) begin wr_en = 1; wr_idx = 4'd12; wr_data = lw; wr_keep = 1; end
      else if (k == 5) begin wr_en = 1; wr_idx = 4'd4; wr_data = lw; wr_keep = 1; end
      else wr_en = 0;
      if (k == 7) begin q_start = 1; q_word = tab[0]; end else q_start = 0;
      @(negedge clk);
    end
    wr_en = 0; q_start = 0;
    while (!res_valid) @(negedge clk);
    check("R8 write before compare seen", res_dist, 0);
    check("R8 write on compare edge unseen", res_idx, 12);
    check("R6 busy start ignored", res_dist, 0);
    query(lw, lat);
    check("R8 later query sees new slot", res_idx, 4);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule